// File: doc/BRIEF.md
# Circular command queue fetch engine

This block sits at the front of an interrupt translation unit. Software places 32-byte commands in a ring buffer in memory, tells the block where the ring is, and then moves a write offset forward. The block then reads commands one at a time from memory, starting at its read offset, and hands each one to a downstream consumer. It stops when the read offset catches up with the write offset.

Software reaches the block through a 32-bit register port. Writes take effect on the clock edge and reads are combinational. The port holds an enable/status word, a 64-bit packed queue descriptor, a write offset and a read offset. Memory is read through a request/grant channel. After a grant, that channel returns four 64-bit beats, and any beat may instead report an error. A fetched command waits in the block until the consumer accepts it, so a stalled consumer holds the queue position.

Top module: `cmdq_engine`

## Requirements
- R1: Synchronous active-high reset clears the enable bit, the descriptor and both offsets, and returns the sequencer to idle with `mem_req` and `cmd_valid` low.
- R2: The control word at byte address 0x00 reads bit 31 as 1 and bit 0 as the stored enable. Bit 0 is the only writable bit and every other bit reads 0. The unmapped address 0x04 reads 0.
- R3: The descriptor reads back whole at 0x08 (low half) and 0x0C (high half). Fetch addresses are `{desc[47:12], 12'h000}` plus the read offset. The queue length in bytes is `(desc[7:0] + 1) * 4096`.
- R4: Descriptor writes are ignored while enable is 1. An accepted descriptor write, to either half, clears the read offset to 0.
- R5: The write offset (0x10) and the read offset (0x18) keep only bits [19:5], and all other bits read 0. The upper halves (0x14, 0x1C) read 0 and ignore writes. The read offset cannot be written.
- R6: A write-offset value (after masking) greater than the queue length is dropped and changes no state.
- R7: While the read offset differs from the write offset, the block fetches one command at the current fetch address and presents it with beat 0 in `cmd_data[63:0]` up to beat 3 in `cmd_data[255:192]`. This happens whether or not enable is set.
- R8: The read offset moves forward by 32 only when the consumer accepts a command, and wraps to 0 when it reaches the queue length. While `cmd_ready` is low, `cmd_valid` and `cmd_data` hold.
- R9: A write-offset update made during a fetch only moves the target, and fetching continues until the read offset equals the new value.
- R10: A beat returned with `mem_rerr` drops that command, sets the write offset equal to the current read offset and stops fetching.
- R11: `mem_req` and `mem_addr` stay stable until `mem_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Command read request |
| mem_addr | output | 48 | Byte address of the command |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Response beat valid |
| mem_rdata | input | 64 | Response beat data |
| mem_rerr | input | 1 | Response beat carries an error |
| cmd_valid | output | 1 | Fetched command available |
| cmd_data | output | 256 | Fetched command, beat 0 lowest |
| cmd_ready | input | 1 | Consumer accepts the command |

## Verification
The bench builds the block with its default parameters: 48-bit addresses, 20-bit offsets and four 64-bit beats per command. Because the size field is programmed to 0 and 1 at run time, the queue is only 128 or 256 commands long. That brings wrap-around, targets that lie behind the read offset, and the case where a descriptor write clears the read offset all within a few thousand cycles. Random grant delays, gaps between beats and consumer back-pressure mix with directed stalls and with an injected beat error at a chosen queue slot.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int REG_AW = 5;

    localparam logic [REG_AW-1:0] RA_CTRL    = 5'h00;
    localparam logic [REG_AW-1:0] RA_BASE_LO = 5'h08;
    localparam logic [REG_AW-1:0] RA_BASE_HI = 5'h0C;
    localparam logic [REG_AW-1:0] RA_WOFF_LO = 5'h10;
    localparam logic [REG_AW-1:0] RA_WOFF_HI = 5'h14;
    localparam logic [REG_AW-1:0] RA_ROFF_LO = 5'h18;
    localparam logic [REG_AW-1:0] RA_ROFF_HI = 5'h1C;

    localparam int CTRL_IDLE_BIT = 31;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_BEAT = 2'd2,
        FS_PUSH = 2'd3
    } fetch_st_e;

endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
    import cmdq_pkg::*;
#(
    parameter int OFF_W   = 20,
    parameter int CMD_SH  = 5,
    parameter int SIZE_W  = 8,
    parameter int PAGE_SH = 12,
    parameter int PA_W    = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_adv,
    input  logic              fetch_abort,
    output logic [PA_W-1:0]   base_addr,
    output logic [OFF_W-1:0]  roff,
    output logic [OFF_W-1:0]  woff
);

    localparam int LEN_W = SIZE_W + PAGE_SH + 1;
    localparam logic [OFF_W-1:0] OFF_MASK  = {OFF_W{1'b1}} << CMD_SH;
    localparam logic [LEN_W-1:0] CMD_BYTES = LEN_W'(1) << CMD_SH;
    localparam logic [OFF_W-1:0] OFF_STEP  = OFF_W'(1) << CMD_SH;

    typedef struct packed {
        logic             en;
        logic [63:0]      base;
        logic [OFF_W-1:0] roff;
        logic [OFF_W-1:0] woff;
    } regs_t;

    regs_t q, d;

    logic [LEN_W-1:0] qlen;
    logic [LEN_W-1:0] roff_inc;
    logic [OFF_W-1:0] woff_cand;
    logic             base_wr;

    assign qlen      = (LEN_W'(q.base[SIZE_W-1:0]) + LEN_W'(1)) << PAGE_SH;
    assign base_addr = {q.base[PA_W-1:PAGE_SH], {PAGE_SH{1'b0}}};
    assign roff      = q.roff;
    assign woff      = q.woff;
    assign woff_cand = reg_wdata[OFF_W-1:0] & OFF_MASK;
    assign roff_inc  = LEN_W'(q.roff) + CMD_BYTES;
    assign base_wr   = reg_wen && (reg_addr == RA_BASE_LO || reg_addr == RA_BASE_HI);

    // next-state computation
    always_comb begin
        d = q;
        if (fetch_adv) begin
            d.roff = (roff_inc >= qlen) ? '0 : roff_inc[OFF_W-1:0];
        end
        if (reg_wen) begin
            case (reg_addr)
                RA_CTRL: d.en = reg_wdata[0];
                RA_BASE_LO: begin
                    if (!q.en) begin
                        d.base[31:0] = reg_wdata;
                        d.roff       = '0;
                    end
                end
                RA_BASE_HI: begin
                    if (!q.en) begin
                        d.base[63:32] = reg_wdata;
                        d.roff        = '0;
                    end
                end
                RA_WOFF_LO: begin
                    if (LEN_W'(woff_cand) <= qlen) begin
                        d.woff = woff_cand;
                    end
                end
                default: ;
            endcase
        end
        if (fetch_abort) begin
            d.woff = q.roff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CTRL_IDLE_BIT] = 1'b1;
                reg_rdata[0]             = q.en;
            end
            RA_BASE_LO: reg_rdata = q.base[31:0];
            RA_BASE_HI: reg_rdata = q.base[63:32];
            RA_WOFF_LO: reg_rdata = 32'(q.woff);
            RA_ROFF_LO: reg_rdata = 32'(q.roff);
            default:    reg_rdata = '0;
        endcase
    end

    a_r4_base_locked: assert property (@(posedge clk) disable iff (rst)
        (q.en && base_wr) |=> $stable(q.base));

    a_r4_roff_cleared: assert property (@(posedge clk) disable iff (rst)
        (!q.en && base_wr) |=> (q.roff == '0));

    a_r6_woff_dropped: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && reg_addr == RA_WOFF_LO && (LEN_W'(woff_cand) > qlen) && !fetch_abort)
        |=> $stable(q.woff));

    a_r10_rollback: assert property (@(posedge clk) disable iff (rst)
        fetch_abort |=> (q.woff == $past(q.roff)));

    a_r8_step: assert property (@(posedge clk) disable iff (rst)
        (fetch_adv && !(base_wr && !q.en))
        |=> (q.roff == $past(q.roff) + OFF_STEP || q.roff == '0));

endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
    import cmdq_pkg::*;
#(
    parameter int BEATS  = 4,
    parameter int BEAT_W = 64,
    parameter int OFF_W  = 20,
    parameter int PA_W   = 48
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PA_W-1:0]         base_addr,
    input  logic [OFF_W-1:0]        roff,
    input  logic [OFF_W-1:0]        woff,
    output logic                    mem_req,
    output logic [PA_W-1:0]         mem_addr,
    input  logic                    mem_gnt,
    input  logic                    mem_rvalid,
    input  logic [BEAT_W-1:0]       mem_rdata,
    input  logic                    mem_rerr,
    output logic                    cmd_valid,
    output logic [BEATS*BEAT_W-1:0] cmd_data,
    input  logic                    cmd_ready,
    output logic                    fetch_adv,
    output logic                    fetch_abort
);

    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    typedef struct packed {
        fetch_st_e                    st;
        logic [CNT_W-1:0]             cnt;
        logic [BEATS-1:0][BEAT_W-1:0] data;
    } fs_t;

    fs_t q, d;

    assign mem_addr = base_addr + PA_W'(roff);
    assign cmd_data = q.data;

    always_comb begin
        d           = q;
        mem_req     = 1'b0;
        cmd_valid   = 1'b0;
        fetch_adv   = 1'b0;
        fetch_abort = 1'b0;
        case (q.st)
            FS_IDLE: begin
                if (roff != woff) begin
                    d.st = FS_REQ;
                end
            end
            FS_REQ: begin
                mem_req = 1'b1;
                if (mem_gnt) begin
                    d.st  = FS_BEAT;
                    d.cnt = '0;
                end
            end
            FS_BEAT: begin
                if (mem_rvalid) begin
                    if (mem_rerr) begin
                        fetch_abort = 1'b1;
                        d.st        = FS_IDLE;
                    end else begin
                        d.data[q.cnt] = mem_rdata;
                        if (q.cnt == LAST) begin
                            d.st = FS_PUSH;
                        end else begin
                            d.cnt = q.cnt + CNT_W'(1);
                        end
                    end
                end
            end
            FS_PUSH: begin
                cmd_valid = 1'b1;
                if (cmd_ready) begin
                    fetch_adv = 1'b1;
                    d.st      = FS_IDLE;
                end
            end
            default: d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    a_r8_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    a_r10_no_push_after_error: assert property (@(posedge clk) disable iff (rst)
        fetch_abort |=> !cmd_valid);

    a_r1_single_activity: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_req, cmd_valid, fetch_abort}));

endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
    import cmdq_pkg::*;
#(
    parameter int PA_W    = 48,
    parameter int OFF_W   = 20,
    parameter int BEATS   = 4,
    parameter int BEAT_W  = 64,
    parameter int SIZE_W  = 8,
    parameter int PAGE_SH = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wen,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic                    mem_req,
    output logic [PA_W-1:0]         mem_addr,
    input  logic                    mem_gnt,
    input  logic                    mem_rvalid,
    input  logic [BEAT_W-1:0]       mem_rdata,
    input  logic                    mem_rerr,
    output logic                    cmd_valid,
    output logic [BEATS*BEAT_W-1:0] cmd_data,
    input  logic                    cmd_ready
);

    localparam int CMD_SH = $clog2(BEATS * BEAT_W / 8);

    logic [PA_W-1:0]  base_addr;
    logic [OFF_W-1:0] roff;
    logic [OFF_W-1:0] woff;
    logic             fetch_adv;
    logic             fetch_abort;

    cmdq_regs #(
        .OFF_W  (OFF_W),
        .CMD_SH (CMD_SH),
        .SIZE_W (SIZE_W),
        .PAGE_SH(PAGE_SH),
        .PA_W   (PA_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wen    (reg_wen),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .fetch_adv  (fetch_adv),
        .fetch_abort(fetch_abort),
        .base_addr  (base_addr),
        .roff       (roff),
        .woff       (woff)
    );

    cmdq_fetch #(
        .BEATS (BEATS),
        .BEAT_W(BEAT_W),
        .OFF_W (OFF_W),
        .PA_W  (PA_W)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .base_addr  (base_addr),
        .roff       (roff),
        .woff       (woff),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_rerr   (mem_rerr),
        .cmd_valid  (cmd_valid),
        .cmd_data   (cmd_data),
        .cmd_ready  (cmd_ready),
        .fetch_adv  (fetch_adv),
        .fetch_abort(fetch_abort)
    );

endmodule

// File: tb/cmdq_engine_bench.sv
module cmdq_engine_bench;
    import cmdq_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wen = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         mem_req;
    logic [47:0]  mem_addr;
    logic         mem_gnt = 1'b0;
    logic         mem_rvalid = 1'b0;
    logic [63:0]  mem_rdata = '0;
    logic         mem_rerr = 1'b0;
    logic         cmd_valid;
    logic [255:0] cmd_data;
    logic         cmd_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [47:0] m_base_addr = '0;
    int          m_len = 4096;
    int          exp_roff = 0;
    int          exp_woff = 0;
    int          n_cmds = 0;
    bit          stall = 1'b0;

    // memory model state
    bit          m_busy = 1'b0;
    int          m_delay = 0;
    int          m_beat = 0;
    logic [47:0] m_addr = '0;
    bit          err_armed = 1'b0;
    logic [47:0] err_addr = '0;
    int          err_fired = 0;

    cmdq_engine u_cmdq_engine (
        .clk       (clk),
        .rst       (rst),
        .reg_wen   (reg_wen),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_gnt   (mem_gnt),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata),
        .mem_rerr  (mem_rerr),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .cmd_ready (cmd_ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic void check(string req, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endfunction

    function automatic logic [63:0] bdata(logic [47:0] a, int i);
        return {a, 8'hA5, 6'd0, 2'(i)};
    endfunction

    function automatic logic [255:0] cmd_exp(logic [47:0] a);
        logic [255:0] v;
        for (int i = 0; i < 4; i++) v[i*64 +: 64] = bdata(a, i);
        return v;
    endfunction

    function automatic void summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endfunction

    // memory responder
    always @(negedge clk) begin
        mem_gnt    = 1'b0;
        mem_rvalid = 1'b0;
        mem_rerr   = 1'b0;
        mem_rdata  = '0;
        if (rst) begin
            m_busy = 1'b0;
        end else if (m_busy) begin
            if ($urandom % 3 != 0) begin
                mem_rvalid = 1'b1;
                if (err_armed && m_addr == err_addr && m_beat == 2) begin
                    mem_rerr  = 1'b1;
                    m_busy    = 1'b0;
                    err_armed = 1'b0;
                    err_fired++;
                    exp_woff  = exp_roff;
                end else begin
                    mem_rdata = bdata(m_addr, m_beat);
                    m_beat++;
                    if (m_beat == 4) m_busy = 1'b0;
                end
            end
        end else if (mem_req) begin
            if (m_delay == 0) begin
                mem_gnt = 1'b1;
                check("R3 R11 request address", 256'(mem_addr), 256'(m_base_addr + 48'(exp_roff)));
                m_addr  = mem_addr;
                m_busy  = 1'b1;
                m_beat  = 0;
                m_delay = $urandom % 3;
            end else begin
                m_delay--;
            end
        end
    end

    // consumer
    always @(negedge clk) begin
        if (rst) begin
            cmd_ready = 1'b0;
        end else begin
            cmd_ready = stall ? 1'b0 : ($urandom % 4 != 0);
            if (cmd_valid && cmd_ready) begin
                check("R7 command data", cmd_data, cmd_exp(m_base_addr + 48'(exp_roff)));
                exp_roff += 32;
                if (exp_roff >= m_len) exp_roff = 0;
                n_cmds++;
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        #1;
        reg_wen   = 1'b1;
        reg_addr  = a;
        reg_wdata = v;
        @(negedge clk);
        #1;
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        #1;
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic set_woff(input int v, input logic [31:0] junk);
        int masked;
        masked = v & 32'h000F_FFE0;
        wr(RA_WOFF_LO, 32'(v) | junk);
        if (masked <= m_len) exp_woff = masked;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] r;
        logic [31:0] w;
        bit done;
        done = 1'b0;
        for (int k = 0; k < 6000 && !done; k++) begin
            @(negedge clk);
            rd(RA_ROFF_LO, r);
            rd(RA_WOFF_LO, w);
            if (r == w && !cmd_valid && !mem_req) done = 1'b1;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s idle timeout act=%0h exp=%0h", tag, r, w);
        end
        check({tag, " read offset"}, 256'(r), 256'(exp_roff));
        check({tag, " write offset"}, 256'(w), 256'(exp_woff));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=%0d exp=%0d", n_chk, 0);
        summary();
        $finish;
    end

    initial begin
        logic [31:0]  v;
        logic [255:0] snap;
        int           start;
        int           cmds0;
        void'($urandom(32'd20251));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(RA_CTRL, v);    check("R1 R2 control after reset", 256'(v), 256'h8000_0000);
        rd(RA_BASE_LO, v); check("R1 descriptor low", 256'(v), 256'h0);
        rd(RA_WOFF_LO, v); check("R1 write offset", 256'(v), 256'h0);
        rd(RA_ROFF_LO, v); check("R1 read offset", 256'(v), 256'h0);
        check("R1 outputs idle", 256'({mem_req, cmd_valid}), 256'h0);
        rd(5'h04, v);      check("R2 unmapped reads zero", 256'(v), 256'h0);

        // R3 descriptor programming (size field 1, 8 KiB)
        wr(RA_BASE_LO, 32'h1234_5301);
        wr(RA_BASE_HI, 32'h0000_00AB);
        m_base_addr = 48'h00AB_1234_5000;
        m_len       = 8192;
        rd(RA_BASE_LO, v); check("R3 descriptor low readback", 256'(v), 256'h1234_5301);
        rd(RA_BASE_HI, v); check("R3 descriptor high readback", 256'(v), 256'h0000_00AB);

        // R2 enable, R4 lock
        wr(RA_CTRL, 32'hFFFF_FFFF);
        rd(RA_CTRL, v);    check("R2 control enabled", 256'(v), 256'h8000_0001);
        wr(RA_BASE_LO, 32'hFFFF_FFFF);
        rd(RA_BASE_LO, v); check("R4 descriptor locked", 256'(v), 256'h1234_5301);

        // R5 masking and R7 fetch of three commands
        set_woff(32'h60, 32'h8000_001F);
        rd(RA_WOFF_LO, v); check("R5 write offset masked", 256'(v), 256'h60);
        wait_idle("R7 three commands");
        check("R7 command count", 256'(n_cmds), 256'd3);

        // R5 upper halves and read-only read offset
        wr(RA_WOFF_HI, 32'hFFFF_FFFF);
        rd(RA_WOFF_HI, v); check("R5 write offset upper half", 256'(v), 256'h0);
        rd(RA_WOFF_LO, v); check("R5 write offset kept", 256'(v), 256'h60);
        wr(RA_ROFF_LO, 32'h0000_0400);
        wr(RA_ROFF_HI, 32'hFFFF_FFFF);
        rd(RA_ROFF_LO, v); check("R5 read offset read-only", 256'(v), 256'h60);
        rd(RA_ROFF_HI, v); check("R5 read offset upper half", 256'(v), 256'h0);

        // R6 out-of-range write offset dropped
        wr(RA_WOFF_LO, 32'h2020);
        rd(RA_WOFF_LO, v); check("R6 oversize offset dropped", 256'(v), 256'h60);
        repeat (10) @(negedge clk);
        check("R6 no fetch started", 256'({mem_req, cmd_valid}), 256'h0);

        // R8 wrap-around
        set_woff(32'h1FE0, 32'h0);
        wait_idle("R8 run to end");
        set_woff(32'h40, 32'h0);
        wait_idle("R8 wrap");

        // R8 stall and R9 target moved during fetch
        stall = 1'b1;
        set_woff(32'h80, 32'h0);
        repeat (30) @(negedge clk);
        check("R8 stalled command valid", 256'(cmd_valid), 256'h1);
        snap = cmd_data;
        rd(RA_ROFF_LO, v); check("R8 stalled read offset held", 256'(v), 256'h40);
        cmds0 = n_cmds;
        set_woff(32'hC0, 32'h0);
        repeat (5) @(negedge clk);
        check("R8 stalled data stable", cmd_data, snap);
        stall = 1'b0;
        wait_idle("R9 extended target");
        check("R9 commands after extension", 256'(n_cmds - cmds0), 256'd4);

        // R10 fetch error at the third slot
        start     = exp_roff;
        err_addr  = m_base_addr + 48'((start + 64) % m_len);
        err_armed = 1'b1;
        err_fired = 0;
        set_woff((start + 160) % m_len, 32'h0);
        wait_idle("R10 error rollback");
        check("R10 error seen", 256'(err_fired), 256'd1);
        rd(RA_WOFF_LO, v); check("R10 write offset at failed slot", 256'(v), 256'((start + 64) % m_len));
        set_woff((start + 96) % m_len, 32'h0);
        wait_idle("R10 retry after error");

        // R4 descriptor write while disabled clears the read offset (size 0)
        wr(RA_CTRL, 32'h0);
        rd(RA_CTRL, v); check("R2 control disabled", 256'(v), 256'h8000_0000);
        exp_roff = 0;
        m_len    = 4096;
        wr(RA_BASE_LO, 32'h1234_5300);
        rd(RA_ROFF_LO, v); check("R4 read offset cleared", 256'(v), 256'h0);
        wait_idle("R7 fetch while disabled");
        wr(RA_CTRL, 32'h1);

        // random phase
        for (int it = 0; it < 30; it++) begin
            set_woff(int'(($urandom % 128) * 32), 32'($urandom % 32));
            if ($urandom % 2 == 1) begin
                repeat ($urandom % 20) @(negedge clk);
                set_woff(int'(($urandom % 128) * 32), 32'h0);
            end
            if ($urandom % 4 == 0) set_woff(4096 + 32 * int'($urandom % 8 + 1), 32'h0);
            wait_idle("R9 random targets");
        end

        summary();
        $finish;
    end

endmodule